// File: doc/BRIEF.md
# Pixel Clock Presence and Rate Monitor

This block runs on the constant internal clock and never touches the incoming video clock. It watches the empty flag of the clock-crossing FIFO that carries pixels into the internal domain. Over a fixed window of internal cycles it counts the cycles on which that FIFO held data. The count is an estimate of the incoming pixel rate relative to the internal clock. A source whose clock has stopped leaves the FIFO empty, so its count falls toward zero.

At the end of every window the count is published as a rate reading. It is also compared with two run-time thresholds that form a hysteresis band, and the result is a video-present flag that selects between live video and the local splash screen. Each time the flag changes from absent to present, the block emits a one-cycle restart pulse so that the FIFO can be flushed before live pixels are used. After reset the flag reads absent, so the splash screen is shown until a complete window has confirmed an active input.

Top module: `pix_rate_mon`

## Requirements
- R1: A measurement window lasts exactly 2^WIN_LOG2 internal cycles. When a window ends, `rateReading` holds the number of cycles in that window on which `fifoEmpty` was 0. The count restarts from zero, so each window's reading depends only on its own cycles.
- R2: `rateValid` is high for exactly one cycle per window, in the cycle in which `rateReading` first shows the new value. It is never high at any other time.
- R3: During reset and until the first window ends, `videoPresent`, `fifoRestart` and `rateValid` are 0, and `rateReading` is 0 until that point. The first reading appears 2^WIN_LOG2 cycles after reset is released.
- R4: While absent, `videoPresent` rises at a window end only when that window's count is strictly greater than `thrHigh`. A count equal to `thrHigh` leaves it absent.
- R5: While present, `videoPresent` falls at a window end only when that window's count is strictly less than `thrLow`. A count equal to `thrLow` leaves it present.
- R6: A window whose count lies between the thresholds leaves `videoPresent` unchanged in either state, and `videoPresent` changes only in the cycle that `rateValid` marks.
- R7: `fifoRestart` is a one-cycle pulse, high together with `rateValid`, on every absent-to-present change and at no other time.
- R8: The reading depends only on how many cycles within the window were not empty, not on where those cycles fall in the window.
- R9: A window with data on every cycle reads the full value 2^WIN_LOG2 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Constant internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEmpty | input | 1 | Empty flag of the crossing FIFO, read-clock domain |
| thrHigh | input | WIN_LOG2+1 | A count above this declares the input present |
| thrLow | input | WIN_LOG2+1 | A count below this declares the input absent |
| rateReading | output | WIN_LOG2+1 | Not-empty cycle count of the last finished window |
| rateValid | output | 1 | One-cycle strobe marking a new reading |
| videoPresent | output | 1 | High while live video should be shown |
| fifoRestart | output | 1 | One-cycle FIFO flush request on an absent-to-present change |

## Verification
The bench builds the block with WIN_LOG2 = 4, so each window is 16 cycles. At that size the empty and full windows, counts that sit exactly on either threshold, and every presence transition can each be reached in a handful of windows. The narrow count field also shows whether a completely full window wraps. The thresholds are changed at run time between windows to confirm that they are read at each window end, and the same count is driven at the front of the window, at the back, and interleaved with empty cycles.

// File: rtl/pix_rate_mon_pkg.sv
package pix_rate_mon_pkg;

  // Strobes handed from the control half to the counting half.
  typedef struct packed {
    logic windowEnd;   // last cycle of the current window
    logic latchRate;   // publish the finishing count this cycle
  } monStrobe_t;

endpackage

// File: rtl/pix_rate_mon_dp.sv
module pix_rate_mon_dp
  import pix_rate_mon_pkg::*;
#(
  parameter int WIN_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEmpty,
  input  monStrobe_t        strobe,
  input  logic [WIN_LOG2:0] thrHigh,
  input  logic [WIN_LOG2:0] thrLow,
  output logic [WIN_LOG2:0] rateReading,
  output logic              aboveHigh,
  output logic              belowLow
);

  localparam int CNT_W = WIN_LOG2 + 1;
  localparam logic [CNT_W-1:0] WIN_CNT = {1'b1, {WIN_LOG2{1'b0}}};

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] rateQ;
  logic [CNT_W-1:0] windowCount;

  // Count including the current cycle, so the window spans exactly WIN cycles.
  assign windowCount = countQ + {{(CNT_W-1){1'b0}}, ~fifoEmpty};

  assign aboveHigh = windowCount > thrHigh;
  assign belowLow  = windowCount < thrLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      rateQ  <= '0;
    end else begin
      if (strobe.windowEnd) countQ <= '0;
      else                  countQ <= windowCount;
      if (strobe.latchRate) rateQ  <= windowCount;
    end
  end

  assign rateReading = rateQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ < WIN_CNT); // R9

  AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rateQ <= WIN_CNT); // R1

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchRate |=> $stable(rateQ)); // R2

endmodule

// File: rtl/pix_rate_mon_ctrl.sv
module pix_rate_mon_ctrl
  import pix_rate_mon_pkg::*;
#(
  parameter int WIN_LOG2 = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveHigh,
  input  logic       belowLow,
  output monStrobe_t strobe,
  output logic       rateValid,
  output logic       videoPresent,
  output logic       fifoRestart
);

  logic [WIN_LOG2-1:0] timerQ;
  logic                presentQ;
  logic                validQ;
  logic                restartQ;
  logic                winEnd;
  logic                goPresent;
  logic                goAbsent;

  assign winEnd    = &timerQ;
  assign goPresent = winEnd && !presentQ && aboveHigh;
  assign goAbsent  = winEnd &&  presentQ && belowLow;

  always_comb begin
    strobe.windowEnd = winEnd;
    strobe.latchRate = winEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ   <= '0;
      presentQ <= 1'b0;
      validQ   <= 1'b0;
      restartQ <= 1'b0;
    end else begin
      timerQ   <= timerQ + 1'b1;
      validQ   <= winEnd;
      restartQ <= goPresent;
      if (goPresent)     presentQ <= 1'b1;
      else if (goAbsent) presentQ <= 1'b0;
    end
  end

  assign rateValid    = validQ;
  assign videoPresent = presentQ;
  assign fifoRestart  = restartQ;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ); // R2

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    restartQ |=> !restartQ); // R7

  AST_RESTART_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    restartQ |-> (validQ && presentQ)); // R7

  AST_PRESENT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> $stable(presentQ)); // R6

  AST_RISE_NEEDS_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (winEnd && !presentQ && !aboveHigh) |=> !presentQ); // R4

  AST_FALL_NEEDS_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (winEnd && presentQ && !belowLow) |=> presentQ); // R5

endmodule

// File: rtl/pix_rate_mon.sv
module pix_rate_mon
  import pix_rate_mon_pkg::*;
#(
  parameter int WIN_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEmpty,
  input  logic [WIN_LOG2:0] thrHigh,
  input  logic [WIN_LOG2:0] thrLow,
  output logic [WIN_LOG2:0] rateReading,
  output logic              rateValid,
  output logic              videoPresent,
  output logic              fifoRestart
);

  monStrobe_t strobe;
  logic       aboveHigh;
  logic       belowLow;

  pix_rate_mon_ctrl #(.WIN_LOG2(WIN_LOG2)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .aboveHigh    (aboveHigh),
    .belowLow     (belowLow),
    .strobe       (strobe),
    .rateValid    (rateValid),
    .videoPresent (videoPresent),
    .fifoRestart  (fifoRestart)
  );

  pix_rate_mon_dp #(.WIN_LOG2(WIN_LOG2)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fifoEmpty   (fifoEmpty),
    .strobe      (strobe),
    .thrHigh     (thrHigh),
    .thrLow      (thrLow),
    .rateReading (rateReading),
    .aboveHigh   (aboveHigh),
    .belowLow    (belowLow)
  );

  AST_RESTART_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    fifoRestart |-> videoPresent); // R7

endmodule

// File: tb/pix_rate_mon_bench.sv
`timescale 1ns/1ps
module pix_rate_mon_bench;

  localparam int WL  = 4;
  localparam int WIN = 1 << WL;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fifoEmpty = 1'b1;
  logic [WL:0]   thrHigh = 5'd12;
  logic [WL:0]   thrLow  = 5'd4;
  logic [WL:0]   rateReading;
  logic          rateValid;
  logic          videoPresent;
  logic          fifoRestart;

  always #2.5 clk = ~clk;

  pix_rate_mon #(.WIN_LOG2(WL)) u_pix_rate_mon (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty),
    .thrHigh(thrHigh), .thrLow(thrLow),
    .rateReading(rateReading), .rateValid(rateValid),
    .videoPresent(videoPresent), .fifoRestart(fifoRestart)
  );

  int checks = 0;
  int fails  = 0;
  int posCnt = 0;
  bit seenFirst = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    int    count;
    bit    present;
    bit    restart;
    string req;
  } item_t;

  item_t sb[$];
  bit modelPresent = 0;

  // mode 0: not-empty cycles first, 1: last, 2: on even cycles
  task automatic runWindow(int n, int mode, string req);
    item_t it;
    bit nxt;
    nxt = modelPresent ? !(n < int'(thrLow)) : (n > int'(thrHigh));
    it.count = n; it.present = nxt; it.restart = !modelPresent && nxt; it.req = req;
    sb.push_back(it);
    modelPresent = nxt;
    for (int i = 0; i < WIN; i++) begin
      case (mode)
        0:       fifoEmpty = !(i < n);
        1:       fifoEmpty = !(i >= WIN - n);
        default: fifoEmpty = !((i % 2 == 0) && (i / 2 < n));
      endcase
      @(negedge clk);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) posCnt <= 0;
    else       posCnt <= posCnt + 1;
  end

  // Monitor: pops expected window results as the design publishes them.
  always @(negedge clk) begin
    if (rstN) begin
      if (rateValid) begin
        if (!seenFirst) begin
          check(posCnt == WIN, "R3 first reading cycle", posCnt, WIN);
          seenFirst = 1;
        end
        check(posCnt % WIN == 0, "R1 window length", posCnt % WIN, 0);
        if (sb.size() == 0) begin
          check(0, "R2 unexpected rateValid", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(int'(rateReading) == it.count, {it.req, " rateReading"}, int'(rateReading), it.count);
          check(videoPresent == it.present, {it.req, " videoPresent"}, int'(videoPresent), int'(it.present));
          check(fifoRestart == it.restart, {it.req, " R7 fifoRestart"}, int'(fifoRestart), int'(it.restart));
        end
      end else begin
        if (fifoRestart) check(0, "R7 restart without rateValid", 1, 0);
        if (!seenFirst && videoPresent) check(0, "R3 present before first window", 1, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(videoPresent == 0, "R3 videoPresent in reset", int'(videoPresent), 0);
    check(rateValid == 0,    "R3 rateValid in reset", int'(rateValid), 0);
    check(fifoRestart == 0,  "R3 fifoRestart in reset", int'(fifoRestart), 0);
    check(rateReading == 0,  "R3 rateReading in reset", int'(rateReading), 0);
    rstN = 1'b1;
    runWindow(16, 0, "R9 full window");
    runWindow(10, 0, "R6 band while present");
    runWindow(4,  1, "R5 equal to low");
    runWindow(3,  0, "R5 below low");
    runWindow(8,  1, "R6 band while absent");
    runWindow(12, 0, "R4 equal to high");
    runWindow(13, 1, "R4 above high");
    runWindow(0,  0, "R5 stopped input");
    thrHigh = 5'd6;
    thrLow  = 5'd2;
    runWindow(7,  0, "R4 new high threshold");
    runWindow(2,  1, "R6 equal low new threshold");
    runWindow(1,  0, "R5 new low threshold");
    runWindow(5,  2, "R8 interleaved");
    runWindow(5,  1, "R8 back loaded");
    runWindow(7,  2, "R8 interleaved rise");
    runWindow(0,  1, "R1 empty window");
    fifoEmpty = 1'b1;
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2 every window reported", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule